// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that a compiler has moved above earlier stores. When such a load issues early, its destination register tag and its address are written into a small associative table. Every later store broadcasts its address. Any valid entry whose word address equals the store's word address is invalidated, because that load may have read stale data.

At the load's original place in the program, a check operation presents the register tag. One cycle later the block answers either "keep" or "re-execute". It answers "keep" only when an intact entry for that tag is still present, and a "keep" answer releases that entry.

Entries are found by register tag, so a new early load to the same tag replaces the old one. When no entry is free, an entry is evicted in a rotating order. Eviction is always safe: a missing entry can only cause a replay, never a wrong "keep". Address width, tag width, entry count and the victim policy are all parameters.

Top module: `spec_load_table`

## Requirements
- R1: While `rst` is high and after it falls, the table holds no entries, and `rsp_valid` and `rsp_replay` are 0.
- R2: An early load (`adv_valid`) records its tag and word address (`adv_addr[ADDR_W-1:2]`). If no store kills the entry, a later check of that tag answers keep, with `rsp_replay` = 0.
- R3: An early load whose tag matches a valid entry overwrites that entry. At most one valid entry ever exists per tag, and only the newest address is compared.
- R4: A store whose bits [ADDR_W-1:2] equal those of a valid entry invalidates that entry. Address bits [1:0] are ignored. A later check of that tag answers re-execute.
- R5: A store whose word address matches no valid entry changes nothing, and checks of the other entries still answer keep.
- R6: A check whose tag has no valid entry answers re-execute.
- R7: A check that answers keep frees its entry, so a second check of the same tag answers re-execute.
- R8: A store in the same cycle as a check counts against the checked entry; a matching address gives re-execute.
- R9: When a store and an early load to the same word address occur in one cycle, the new entry is valid afterwards.
- R10: An early load with a new tag takes the lowest-index free entry. When all entries are valid, it evicts the entry at a rotating pointer, which starts at 0 after reset, advances by one on each eviction and wraps after ENTRIES-1. A check of the evicted tag answers re-execute.
- R11: A check and an early load of the same tag in one cycle: the check sees the state before that cycle, and the new entry stays valid even if the check answers keep.
- R12: `rsp_valid` is 1 exactly one clock after a cycle with `chk_valid` high, and is 0 otherwise. `rsp_replay` is 1 for re-execute and 0 for keep, and is 0 when `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_valid | input | 1 | Early load issues this cycle |
| adv_tag | input | TAG_W | Destination register tag of the early load |
| adv_addr | input | ADDR_W | Byte address of the early load |
| st_valid | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| rsp_valid | output | 1 | Check response valid (one cycle after `chk_valid`) |
| rsp_replay | output | 1 | 1 = re-execute the load, 0 = keep the speculative result |

## Verification
A corrupted tag, address or valid bit shows up at the ports only through a later check, one cycle after that check is issued. A lost invalidation shows as a wrong keep. A stale valid bit shows as a keep on a second check, or as an eviction of the wrong entry. A pointer that drifts evicts the wrong tag, and that shows only at the first check of a tag that should have survived, which can be many cycles later. For this reason the reference model runs alongside the block on every cycle. The directed sequences place the check directly after each eviction, kill and overwrite, so a fault appears on the next response.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic [0:0] {
    VICTIM_ROTATE = 1'b0,
    VICTIM_LOWEST = 1'b1
  } victim_e;

  localparam int unsigned MAX_ENTRIES = 64;

  // Index of the lowest set bit; returns 0 for an all-zero vector.
  function automatic int unsigned lowest_set(input logic [MAX_ENTRIES-1:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = MAX_ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/slt_match.sv
module slt_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned WADDR_W = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [TAG_W-1:0]   tag_q   [ENTRIES],
  input  logic [WADDR_W-1:0] waddr_q [ENTRIES],
  input  logic [TAG_W-1:0]   chk_tag,
  input  logic [TAG_W-1:0]   adv_tag,
  input  logic               st_valid,
  input  logic [WADDR_W-1:0] st_waddr,
  output logic [ENTRIES-1:0] chk_hit,
  output logic [ENTRIES-1:0] adv_hit,
  output logic [ENTRIES-1:0] st_kill
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign chk_hit[e] = valid_q[e] && (tag_q[e] == chk_tag);
    assign adv_hit[e] = valid_q[e] && (tag_q[e] == adv_tag);
    assign st_kill[e] = st_valid && valid_q[e] && (waddr_q[e] == st_waddr);
  end

  AST_TAG_UNIQUE_CHK: assert property (@(posedge clk) disable iff (rst) $onehot0(chk_hit)); // R3
  AST_TAG_UNIQUE_ADV: assert property (@(posedge clk) disable iff (rst) $onehot0(adv_hit)); // R3

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc
  import slt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter victim_e     POLICY  = VICTIM_ROTATE,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_req,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] adv_hit,
  output logic [IDX_W-1:0]   alloc_idx
);

  logic             any_hit;
  logic             any_free;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] victim_idx;
  logic             evict;

  assign any_hit  = |adv_hit;
  assign any_free = ~&valid_q;
  assign hit_idx  = IDX_W'(lowest_set(MAX_ENTRIES'(adv_hit)));
  assign free_idx = IDX_W'(lowest_set(MAX_ENTRIES'(~valid_q)));
  assign evict    = alloc_req && !any_hit && !any_free;

  always_comb begin
    if (any_hit)       alloc_idx = hit_idx;
    else if (any_free) alloc_idx = free_idx;
    else               alloc_idx = victim_idx;
  end

  if (POLICY == VICTIM_ROTATE) begin : g_rotate
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q <= '0;
      end else if (evict) begin
        if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
        else                              ptr_q <= ptr_q + 1'b1;
      end
    end

    assign victim_idx = ptr_q;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      ptr_q <= IDX_W'(ENTRIES - 1)); // R10
    AST_PTR_STEPS_ON_EVICT: assert property (@(posedge clk) disable iff (rst)
      !evict |=> $stable(ptr_q)); // R10
  end else begin : g_lowest
    assign victim_idx = '0;
  end

endmodule

// File: rtl/slt_entries.sv
module slt_entries #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned WADDR_W = 30,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic [WADDR_W-1:0] alloc_waddr,
  input  logic [ENTRIES-1:0] kill,
  input  logic               free_en,
  input  logic [IDX_W-1:0]   free_idx,
  output logic [ENTRIES-1:0] valid_q,
  output logic [TAG_W-1:0]   tag_q   [ENTRIES],
  output logic [WADDR_W-1:0] waddr_q [ENTRIES]
);

  logic [ENTRIES-1:0] valid_d;

  // Priority: store kills, then a freeing check, then allocation overrides both.
  always_comb begin
    valid_d = valid_q & ~kill;
    if (free_en)  valid_d[free_idx]  = 1'b0;
    if (alloc_en) valid_d[alloc_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // Payload arrays carry no reset; they are qualified by valid_q.
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[alloc_idx]   <= alloc_tag;
      waddr_q[alloc_idx] <= alloc_waddr;
    end
  end

  AST_ALLOC_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> valid_q[$past(alloc_idx)]); // R9

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned ENTRIES = 8,
  parameter victim_e     POLICY  = VICTIM_ROTATE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_valid,
  input  logic [TAG_W-1:0]  adv_tag,
  input  logic [ADDR_W-1:0] adv_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              rsp_valid,
  output logic              rsp_replay
);

  localparam int unsigned WADDR_W = ADDR_W - 2;
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [WADDR_W-1:0] adv_waddr;
  logic [WADDR_W-1:0] st_waddr;
  logic               unused_lowbits;

  assign adv_waddr      = adv_addr[ADDR_W-1:2];
  assign st_waddr       = st_addr[ADDR_W-1:2];
  assign unused_lowbits = ^{adv_addr[1:0], st_addr[1:0]};

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [WADDR_W-1:0] waddr_q [ENTRIES];
  logic [ENTRIES-1:0] chk_hit;
  logic [ENTRIES-1:0] adv_hit;
  logic [ENTRIES-1:0] st_kill;
  logic [IDX_W-1:0]   alloc_idx;
  logic [IDX_W-1:0]   chk_idx;
  logic               chk_keep;

  slt_match #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .WADDR_W (WADDR_W)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .valid_q  (valid_q),
    .tag_q    (tag_q),
    .waddr_q  (waddr_q),
    .chk_tag  (chk_tag),
    .adv_tag  (adv_tag),
    .st_valid (st_valid),
    .st_waddr (st_waddr),
    .chk_hit  (chk_hit),
    .adv_hit  (adv_hit),
    .st_kill  (st_kill)
  );

  slt_alloc #(
    .ENTRIES (ENTRIES),
    .POLICY  (POLICY)
  ) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .alloc_req (adv_valid),
    .valid_q   (valid_q),
    .adv_hit   (adv_hit),
    .alloc_idx (alloc_idx)
  );

  // Keep only when an intact entry exists and no store in this cycle hits it.
  assign chk_idx  = IDX_W'(lowest_set(MAX_ENTRIES'(chk_hit)));
  assign chk_keep = chk_valid && (|chk_hit) && !(|(chk_hit & st_kill));

  slt_entries #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .WADDR_W (WADDR_W)
  ) u_entries (
    .clk         (clk),
    .rst         (rst),
    .alloc_en    (adv_valid),
    .alloc_idx   (alloc_idx),
    .alloc_tag   (adv_tag),
    .alloc_waddr (adv_waddr),
    .kill        (st_kill),
    .free_en     (chk_keep),
    .free_idx    (chk_idx),
    .valid_q     (valid_q),
    .tag_q       (tag_q),
    .waddr_q     (waddr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_replay <= 1'b0;
    end else begin
      rsp_valid  <= chk_valid;
      rsp_replay <= chk_valid && !chk_keep;
    end
  end

  // Observation helpers for the properties below.
  logic [ENTRIES-1:0] pres_chk_tag;
  logic [ENTRIES-1:0] pres_st_addr;
  logic [ENTRIES-1:0] pres_adv_pair;
  logic               chk_past_tag_live;
  logic               st_past_addr_live;
  logic               adv_past_pair_live;
  logic [TAG_W-1:0]   chk_tag_d;
  logic [TAG_W-1:0]   adv_tag_d;
  logic [WADDR_W-1:0] st_waddr_d;
  logic [WADDR_W-1:0] adv_waddr_d;

  always_ff @(posedge clk) begin
    chk_tag_d   <= chk_tag;
    adv_tag_d   <= adv_tag;
    st_waddr_d  <= st_waddr;
    adv_waddr_d <= adv_waddr;
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      pres_chk_tag[e]  = valid_q[e] && (tag_q[e] == chk_tag_d);
      pres_st_addr[e]  = valid_q[e] && (waddr_q[e] == st_waddr_d);
      pres_adv_pair[e] = valid_q[e] && (tag_q[e] == adv_tag_d) && (waddr_q[e] == adv_waddr_d);
    end
  end

  assign chk_past_tag_live  = |pres_chk_tag;
  assign st_past_addr_live  = |pres_st_addr;
  assign adv_past_pair_live = |pres_adv_pair;

  AST_ADV_RECORDED: assert property (@(posedge clk) disable iff (rst)
    adv_valid |=> adv_past_pair_live); // R2
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !adv_valid) |=> !st_past_addr_live); // R4
  AST_CHECK_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !(adv_valid && adv_tag == chk_tag)) |=> !chk_past_tag_live); // R7
  AST_RSP_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_replay); // R12

endmodule

// File: tb/sim_spec_load_table.sv
module sim_spec_load_table;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 5;
  localparam int N      = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              adv_valid = 1'b0;
  logic [TAG_W-1:0]  adv_tag = '0;
  logic [ADDR_W-1:0] adv_addr = '0;
  logic              st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic              chk_valid = 1'b0;
  logic [TAG_W-1:0]  chk_tag = '0;
  logic              rsp_valid;
  logic              rsp_replay;

  always #10 clk = ~clk;

  spec_load_table #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .ENTRIES(N)) u0 (
    .clk(clk), .rst(rst), .adv_valid(adv_valid), .adv_tag(adv_tag), .adv_addr(adv_addr),
    .st_valid(st_valid), .st_addr(st_addr), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .rsp_valid(rsp_valid), .rsp_replay(rsp_replay)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural reference state
  bit m_v [N];
  int m_t [N];
  int m_a [N];
  int m_rr;
  bit exp_v;
  bit exp_r;

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0; exp_v = 0; exp_r = 0;
  endtask

  task automatic model_step(bit av, int at, int aa, bit sv, int sa, bit cv, int ct);
    bit ov [N];
    int found;
    int slot;
    bit keep;
    for (int i = 0; i < N; i++) ov[i] = m_v[i];
    found = -1;
    for (int i = 0; i < N; i++) if (ov[i] && m_t[i] == ct) found = i;
    keep = cv && found >= 0 && !(sv && (m_a[found] >>> 2) == (sa >>> 2));
    for (int i = 0; i < N; i++)
      if (sv && ov[i] && (m_a[i] >>> 2) == (sa >>> 2)) m_v[i] = 0;
    if (keep) m_v[found] = 0;
    if (av) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (ov[i] && m_t[i] == at) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!ov[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1; m_t[slot] = at; m_a[slot] = aa;
    end
    exp_v = cv;
    exp_r = cv && !keep;
  endtask

  task automatic compare(string req);
    checks++;
    if (rsp_valid !== exp_v || rsp_replay !== exp_r) begin
      fails++;
      $display("FAIL %s: got valid=%0b replay=%0b expected valid=%0b replay=%0b",
               req, rsp_valid, rsp_replay, exp_v, exp_r);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after comparing.
  task automatic cyc(bit av, int at, int aa, bit sv, int sa, bit cv, int ct, string req);
    adv_valid = av; adv_tag = TAG_W'(at); adv_addr = ADDR_W'(aa);
    st_valid = sv;  st_addr = ADDR_W'(sa);
    chk_valid = cv; chk_tag = TAG_W'(ct);
    @(posedge clk);
    model_step(av, at, aa, sv, sa, cv, ct);
    @(negedge clk);
    adv_valid = 0; st_valid = 0; chk_valid = 0;
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1;
    adv_valid = 0; st_valid = 0; chk_valid = 0;
    repeat (3) @(negedge clk);
    model_reset();
    compare("R1 during reset");
    rst = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    cyc(0,0,0, 0,0, 1,3, "R1 empty after reset");
    cyc(0,0,0, 0,0, 1,17, "R6 unknown tag");
    // R2 record then keep; R7 second check replays
    cyc(1,3,'h100, 0,0, 0,0, "R2 idle");
    cyc(0,0,0, 0,0, 1,3, "R2 keep");
    cyc(0,0,0, 0,0, 1,3, "R7 freed");
    // R4 kill ignoring low bits
    cyc(1,4,'h200, 0,0, 0,0, "R4 idle");
    cyc(0,0,0, 1,'h203, 0,0, "R4 store");
    cyc(0,0,0, 0,0, 1,4, "R4 replay");
    // R5 non-matching store
    cyc(1,5,'h300, 0,0, 0,0, "R5 idle");
    cyc(0,0,0, 1,'h304, 0,0, "R5 store");
    cyc(0,0,0, 0,0, 1,5, "R5 keep");
    // R3 overwrite by tag
    cyc(1,6,'h400, 0,0, 0,0, "R3 idle");
    cyc(1,6,'h500, 0,0, 0,0, "R3 idle");
    cyc(0,0,0, 1,'h400, 0,0, "R3 store old");
    cyc(0,0,0, 0,0, 1,6, "R3 keep");
    // R8 store with check
    cyc(1,7,'h600, 0,0, 0,0, "R8 idle");
    cyc(0,0,0, 1,'h600, 1,7, "R8 replay");
    // R9 store and alloc same address
    cyc(1,8,'h700, 1,'h700, 0,0, "R9 idle");
    cyc(0,0,0, 0,0, 1,8, "R9 keep");
    // R11 check and alloc same tag
    cyc(1,9,'h800, 0,0, 0,0, "R11 idle");
    cyc(1,9,'h900, 0,0, 1,9, "R11 keep old");
    cyc(0,0,0, 0,0, 1,9, "R11 new persists");
    cyc(0,0,0, 0,0, 1,9, "R11 freed");
    // R10 fill and evict
    @(negedge clk);
    do_reset();
    for (int i = 1; i <= N; i++) cyc(1,i,'h1000 + 16*i, 0,0, 0,0, "R10 fill");
    cyc(1,20,'h2000, 0,0, 0,0, "R10 evict");
    cyc(0,0,0, 0,0, 1,1, "R10 evicted replay");
    cyc(0,0,0, 0,0, 1,3, "R10 survivor keep");
    cyc(1,21,'h2100, 0,0, 0,0, "R10 free slot");
    cyc(1,22,'h2200, 0,0, 0,0, "R10 evict next");
    cyc(0,0,0, 0,0, 1,2, "R10 second evicted");
    cyc(0,0,0, 0,0, 1,20, "R10 new keep");
    // Mixed traffic
    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0,1) == 1, $urandom_range(0,11),
          'h3000 + 4*$urandom_range(0,5) + $urandom_range(0,3),
          $urandom_range(0,3) == 0,
          'h3000 + 4*$urandom_range(0,5) + $urandom_range(0,3),
          $urandom_range(0,1) == 1, $urandom_range(0,11), "R12 mixed");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule